// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm and Event Interrupts

The block keeps wall-clock time and a calendar in packed BCD. A one-hertz pulse from outside advances a chain of counters: seconds, minutes, hours, day of month, month, a two-digit year, and a weekday index. Software reaches the block through a small byte-wide register file. It reads and writes through one-cycle strobes, and read data comes back on the clock edge after the read strobe.

Beside the clock there are three more groups of state:
- a six-field alarm;
- a status byte of sticky event flags, each cleared by writing a one to it;
- an interrupt configuration byte that picks one periodic event and enables the alarm and periodic sources.

A single level interrupt output stays high while an enabled flag is pending. A get-time control bit takes a snapshot of the date and time, so that a multi-byte read sees one consistent instant while the counters keep running.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time fields read 00:00:00, day 01, month 01, year 00, weekday 0. Control reads 0x00, the interrupt configuration reads 0x00, and status reads 0x80, with only the power-up flag (bit 7) set.
- R2: A tick advances the clock only while control bit 0 is 1. With bit 0 at 0, ticks leave every time field unchanged.
- R3: Seconds and minutes go from 0x59 to 0x00 and carry to the next field. Hours go from 0x23 to 0x00 and carry.
- R4: The day goes back to 0x01 after the last day of its month: 0x31 for months 01, 03, 05, 07, 08, 10 and 12; 0x30 for months 04, 06, 09 and 11; and for month 02, 0x29 when the binary year is divisible by four (00 counts) and 0x28 otherwise.
- R5: After the last day, month 0x12 becomes 0x01 and carries into the year. Year 0x99 becomes 0x00.
- R6: The weekday (offset 0x06) counts 0 to 6 and advances only when the hours roll over. It goes from 6 back to 0.
- R7: Writing control with bit 6 set copies the live seconds through year into a snapshot. Reads of offsets 0x00 to 0x05 return the snapshot, and offset 0x06 returns the live weekday. Control bit 6 always reads back 0.
- R8: Status bit 1 reads as control bit 0. Status bits 2, 3, 4 and 5 latch on each second, minute, hour and day boundary. Each flag is visible by the second clock edge after the tick.
- R9: Status bit 6 latches when a tick brings the live seconds, minutes, hours, day, month and year equal to the six alarm registers at offsets 0x07 to 0x0C. A mismatch in any one field leaves the flag clear.
- R10: Writing status (offset 0x0E) clears each flag at a bit position written as 1. Bits written as 0 keep their value, and writing back a value just read clears every flag that was pending.
- R11: The irq output equals (status bit 6 AND configuration bit 3) OR (the periodic flag chosen by configuration bits [1:0], where 0 selects second, 1 minute, 2 hour and 3 day, AND configuration bit 2). It stays high until the flag is cleared.
- R12: When a write to a time register lands in the same cycle as an advancing tick, the written value is stored for that field.
- R13: Offsets 0x10 and 0x11 are plain byte storage. rd_data takes the addressed byte on the clock edge where rd_en is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| addr | input | 5 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The calendar chain is started from boundary instants, each chosen to separate one rule from its neighbours:
- the end-of-century moment, where every field wraps in one tick;
- the end of February in leap and non-leap years, including year 00;
- the end of a 30-day month and of a 31-day month.

The alarm is tried with a full match and with one field off by one, which shows that the comparison covers all six fields. The periodic interrupt is tried with a tick that crosses only a second boundary and with one that crosses a minute boundary, so the interval select shows that it masks the flags it did not pick. A tick that coincides with a seconds write confirms that the written value wins over the increment.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] mnt;
    logic [7:0] hr;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] yr;
    logic [2:0] wday;
  } rtc_time_t;

  localparam int OFS_SEC  = 0;
  localparam int OFS_MNT  = 1;
  localparam int OFS_HR   = 2;
  localparam int OFS_DAY  = 3;
  localparam int OFS_MON  = 4;
  localparam int OFS_YR   = 5;
  localparam int OFS_WDAY = 6;
  localparam int OFS_ALM0 = 7;
  localparam int ALM_N    = 6;
  localparam int OFS_CTRL = 13;
  localparam int OFS_STAT = 14;
  localparam int OFS_CFG  = 15;
  localparam int OFS_TRM0 = 16;
  localparam int OFS_TRM1 = 17;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                input logic [7:0] yr);
    logic [6:0] yb;
    yb = bcd_to_bin(yr);
    case (mon)
      8'h02: return (yb[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FIELDS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [FIELDS-1:0] field_we,
  input  logic [DATA_W-1:0] wdata,
  output rtc_time_t         now,
  output logic              ev_sec,
  output logic              ev_mnt,
  output logic              ev_hr,
  output logic              ev_day
);

  rtc_time_t nxt;
  logic s_last, m_last, h_last, d_last, mo_last, y_last;
  logic c_mnt, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    s_last  = (now.sec == 8'h59);
    m_last  = (now.mnt == 8'h59);
    h_last  = (now.hr  == 8'h23);
    d_last  = (now.day == month_last_day(now.mon, now.yr));
    mo_last = (now.mon == 8'h12);
    y_last  = (now.yr  == 8'h99);
    c_mnt   = adv & s_last;
    c_hr    = c_mnt & m_last;
    c_day   = c_hr & h_last;
    c_mon   = c_day & d_last;
    c_yr    = c_mon & mo_last;
  end

  always_comb begin
    nxt = now;
    if (adv)   nxt.sec = s_last  ? 8'h00 : bcd_inc(now.sec);
    if (c_mnt) nxt.mnt = m_last  ? 8'h00 : bcd_inc(now.mnt);
    if (c_hr)  nxt.hr  = h_last  ? 8'h00 : bcd_inc(now.hr);
    if (c_day) begin
      nxt.day  = d_last ? 8'h01 : bcd_inc(now.day);
      nxt.wday = (now.wday == 3'd6) ? 3'd0 : now.wday + 3'd1;
    end
    if (c_mon) nxt.mon = mo_last ? 8'h01 : bcd_inc(now.mon);
    if (c_yr)  nxt.yr  = y_last  ? 8'h00 : bcd_inc(now.yr);
    if (field_we[OFS_SEC])  nxt.sec  = wdata;
    if (field_we[OFS_MNT])  nxt.mnt  = wdata;
    if (field_we[OFS_HR])   nxt.hr   = wdata;
    if (field_we[OFS_DAY])  nxt.day  = wdata;
    if (field_we[OFS_MON])  nxt.mon  = wdata;
    if (field_we[OFS_YR])   nxt.yr   = wdata;
    if (field_we[OFS_WDAY]) nxt.wday = wdata[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now    <= '{sec: 8'h00, mnt: 8'h00, hr: 8'h00, day: 8'h01,
                  mon: 8'h01, yr: 8'h00, wday: 3'd0};
      ev_sec <= 1'b0;
      ev_mnt <= 1'b0;
      ev_hr  <= 1'b0;
      ev_day <= 1'b0;
    end else begin
      now    <= nxt;
      ev_sec <= adv;
      ev_mnt <= c_mnt;
      ev_hr  <= c_hr;
      ev_day <= c_day;
    end
  end

  // R2: with no tick and no write the time holds
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && field_we == '0) |=> (now == $past(now)));

  // R3: a minute boundary leaves seconds at zero unless seconds were written
  a_r3_min_event_sec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mnt && !$past(field_we[OFS_SEC])) |-> (now.sec == 8'h00));

  // R6: a day boundary leaves hours at zero unless hours were written
  a_r6_day_event_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_day && !$past(field_we[OFS_HR])) |-> (now.hr == 8'h00));

endmodule

// File: rtl/rtc_status.sv
module rtc_status
  import rtc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int EVT_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rtc_time_t         now,
  input  rtc_time_t         alarm,
  input  logic [EVT_N-1:0]  ev,
  input  logic              running,
  input  logic              stat_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [3:0]        cfg,
  output logic [DATA_W-1:0] status,
  output logic              irq
);

  localparam int EVT_LSB = 2;
  localparam int ALM_BIT = EVT_LSB + EVT_N;
  localparam int PWR_BIT = ALM_BIT + 1;

  logic [EVT_N-1:0] per_q;
  logic             alm_q;
  logic             pwr_q;
  logic             match;
  logic             alm_hit;
  logic             per_sel;

  assign match = (now.sec == alarm.sec) && (now.mnt == alarm.mnt) &&
                 (now.hr  == alarm.hr)  && (now.day == alarm.day) &&
                 (now.mon == alarm.mon) && (now.yr  == alarm.yr);
  assign alm_hit = ev[0] & match;

  for (genvar g = 0; g < EVT_N; g++) begin : g_evt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) per_q[g] <= 1'b0;
      else        per_q[g] <= ev[g] | (per_q[g] & ~(stat_we & wdata[EVT_LSB+g]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q <= 1'b0;
      pwr_q <= 1'b1;
    end else begin
      alm_q <= alm_hit | (alm_q & ~(stat_we & wdata[ALM_BIT]));
      pwr_q <= pwr_q & ~(stat_we & wdata[PWR_BIT]);
    end
  end

  assign status  = DATA_W'({pwr_q, alm_q, per_q, running, 1'b0});
  assign per_sel = per_q[cfg[1:0]];
  assign irq     = (alm_q & cfg[3]) | (per_sel & cfg[2]);

  // R10: a one written to the power-up flag clears it for good
  a_r10_pwr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && wdata[PWR_BIT]) |=> !status[PWR_BIT]);

  // R9: the alarm flag only rises after a tick that matched
  a_r9_alarm_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ALM_BIT]) |-> $past(ev[0] && match));

  // R11: with both sources disabled no interrupt is raised
  a_r11_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[3:2] == 2'b00) |-> !irq);

  // R11: a pending alarm with its enable set and no clear keeps irq high
  a_r11_alarm_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ALM_BIT] && cfg[3] && !(stat_we && wdata[ALM_BIT])) |=> (irq || !cfg[3]));

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  localparam int FIELDS = OFS_WDAY + 1;
  localparam int EVT_N  = 4;
  localparam int GET_BIT = 6;
  localparam logic [ADDR_W-1:0] A_ALM0 = ADDR_W'(OFS_ALM0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_TRM0 = ADDR_W'(OFS_TRM0);
  localparam logic [ADDR_W-1:0] A_TRM1 = ADDR_W'(OFS_TRM1);

  rtc_time_t         now;
  rtc_time_t         snap_q;
  rtc_time_t         alarm;
  logic [DATA_W-1:0] alm_q [ALM_N];
  logic [5:0]        ctrl_q;
  logic [3:0]        cfg_q;
  logic [DATA_W-1:0] trm_lo_q, trm_hi_q;
  logic [FIELDS-1:0] field_we;
  logic              adv;
  logic              ctrl_we, stat_we, get_time;
  logic [EVT_N-1:0]  ev;
  logic              ev_sec, ev_mnt, ev_hr, ev_day;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] rd_nxt;

  assign adv      = tick_1hz & ctrl_q[0];
  assign ctrl_we  = wr_en && (addr == A_CTRL);
  assign stat_we  = wr_en && (addr == A_STAT);
  assign get_time = ctrl_we && wr_data[GET_BIT];

  for (genvar f = 0; f < FIELDS; f++) begin : g_fwe
    assign field_we[f] = wr_en && (addr == ADDR_W'(f));
  end

  for (genvar g = 0; g < ALM_N; g++) begin : g_alm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        alm_q[g] <= (g == OFS_DAY || g == OFS_MON) ? DATA_W'(1) : '0;
      else if (wr_en && addr == A_ALM0 + ADDR_W'(g))
        alm_q[g] <= wr_data;
    end
  end

  assign alarm = '{sec: alm_q[OFS_SEC], mnt: alm_q[OFS_MNT], hr: alm_q[OFS_HR],
                   day: alm_q[OFS_DAY], mon: alm_q[OFS_MON], yr: alm_q[OFS_YR],
                   wday: 3'd0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      cfg_q    <= '0;
      trm_lo_q <= '0;
      trm_hi_q <= '0;
      snap_q   <= '{sec: 8'h00, mnt: 8'h00, hr: 8'h00, day: 8'h01,
                    mon: 8'h01, yr: 8'h00, wday: 3'd0};
    end else begin
      if (ctrl_we) ctrl_q <= wr_data[5:0];
      if (get_time) snap_q <= now;
      if (wr_en && addr == A_CFG)  cfg_q    <= wr_data[3:0];
      if (wr_en && addr == A_TRM0) trm_lo_q <= wr_data;
      if (wr_en && addr == A_TRM1) trm_hi_q <= wr_data;
    end
  end

  rtc_timekeeper #(.DATA_W(DATA_W), .FIELDS(FIELDS)) u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .field_we (field_we),
    .wdata    (wr_data),
    .now      (now),
    .ev_sec   (ev_sec),
    .ev_mnt   (ev_mnt),
    .ev_hr    (ev_hr),
    .ev_day   (ev_day)
  );

  assign ev = {ev_day, ev_hr, ev_mnt, ev_sec};

  rtc_status #(.DATA_W(DATA_W), .EVT_N(EVT_N)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .now     (now),
    .alarm   (alarm),
    .ev      (ev),
    .running (ctrl_q[0]),
    .stat_we (stat_we),
    .wdata   (wr_data),
    .cfg     (cfg_q),
    .status  (status),
    .irq     (irq)
  );

  always_comb begin
    rd_nxt = '0;
    case (addr)
      ADDR_W'(OFS_SEC):  rd_nxt = snap_q.sec;
      ADDR_W'(OFS_MNT):  rd_nxt = snap_q.mnt;
      ADDR_W'(OFS_HR):   rd_nxt = snap_q.hr;
      ADDR_W'(OFS_DAY):  rd_nxt = snap_q.day;
      ADDR_W'(OFS_MON):  rd_nxt = snap_q.mon;
      ADDR_W'(OFS_YR):   rd_nxt = snap_q.yr;
      ADDR_W'(OFS_WDAY): rd_nxt = DATA_W'(now.wday);
      A_CTRL:            rd_nxt = DATA_W'(ctrl_q);
      A_STAT:            rd_nxt = status;
      A_CFG:             rd_nxt = DATA_W'(cfg_q);
      A_TRM0:            rd_nxt = trm_lo_q;
      A_TRM1:            rd_nxt = trm_hi_q;
      default: begin
        for (int i = 0; i < ALM_N; i++)
          if (addr == A_ALM0 + ADDR_W'(i)) rd_nxt = alm_q[i];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_nxt;
  end

  // R7: a get-time write captures the live seconds
  a_r7_snapshot_taken: assert property (@(posedge clk) disable iff (!rst_n)
    get_time |=> (snap_q.sec == $past(now.sec)));

  // R13: read data only moves on a read strobe
  a_r13_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R8: status bit 1 follows the run control
  a_r8_run_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we) |=> (status[1] == $past(wr_data[0])));

endmodule

// File: tb/bcd_rtc_core_test.sv
module bcd_rtc_core_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic [4:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq;

  int total = 0;
  int bad = 0;
  logic [7:0] runb = 8'h00;

  always #4 clk = ~clk;

  bcd_rtc_core uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_run(input logic on);
    runb = {7'd0, on};
    wr(5'h0D, runb);
  endtask

  task automatic snap();
    wr(5'h0D, runb | 8'h40);
  endtask

  task automatic load(input logic [7:0] s, m, h, d, mo, y);
    set_run(1'b0);
    wr(5'h00, s); wr(5'h01, m); wr(5'h02, h);
    wr(5'h03, d); wr(5'h04, mo); wr(5'h05, y);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(5'h00, v); check("R1 sec", v, 8'h00);
    rd(5'h01, v); check("R1 min", v, 8'h00);
    rd(5'h02, v); check("R1 hour", v, 8'h00);
    rd(5'h03, v); check("R1 day", v, 8'h01);
    rd(5'h04, v); check("R1 month", v, 8'h01);
    rd(5'h05, v); check("R1 year", v, 8'h00);
    rd(5'h06, v); check("R1 weekday", v, 8'h00);
    rd(5'h0D, v); check("R1 ctrl", v, 8'h00);
    rd(5'h0F, v); check("R1 cfg", v, 8'h00);
    rd(5'h0E, v); check("R1 status", v, 8'h80);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_halt();
    logic [7:0] v;
    tick(); tick();
    snap();
    rd(5'h00, v); check("R2 stopped sec", v, 8'h00);
    rd(5'h0E, v); check("R2 stopped no events", v, 8'h80);
  endtask

  task automatic t_century();
    logic [7:0] v;
    wr(5'h0C, 8'h50);
    load(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
    wr(5'h06, 8'h06);
    set_run(1'b1);
    tick();
    snap();
    rd(5'h00, v); check("R3 sec wrap", v, 8'h00);
    rd(5'h01, v); check("R3 min wrap", v, 8'h00);
    rd(5'h02, v); check("R3 hour wrap", v, 8'h00);
    rd(5'h03, v); check("R4 day wrap", v, 8'h01);
    rd(5'h04, v); check("R5 month wrap", v, 8'h01);
    rd(5'h05, v); check("R5 year wrap", v, 8'h00);
    rd(5'h06, v); check("R6 weekday wrap", v, 8'h00);
    rd(5'h0E, v); check("R8 all events", v, 8'hBE);
    wr(5'h0E, 8'h00);
    rd(5'h0E, v); check("R10 zero write keeps", v, 8'hBE);
    wr(5'h0E, 8'hBE);
    rd(5'h0E, v); check("R10 write back clears", v, 8'h02);
  endtask

  task automatic t_month(input logic [7:0] d, mo, y, ed, emo, input string tag);
    logic [7:0] v;
    load(8'h59, 8'h59, 8'h23, d, mo, y);
    set_run(1'b1);
    tick();
    snap();
    rd(5'h03, v); check({"R4 day ", tag}, v, ed);
    rd(5'h04, v); check({"R4 month ", tag}, v, emo);
    wr(5'h0E, 8'hFF);
  endtask

  task automatic t_weekday();
    logic [7:0] v;
    load(8'h59, 8'h59, 8'h23, 8'h10, 8'h05, 8'h20);
    wr(5'h06, 8'h03);
    set_run(1'b1);
    tick();
    rd(5'h06, v); check("R6 midnight advance", v, 8'h04);
    tick();
    rd(5'h06, v); check("R6 no advance mid-day", v, 8'h04);
    wr(5'h0E, 8'hFF);
  endtask

  task automatic t_snapshot();
    logic [7:0] v;
    load(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h10);
    set_run(1'b1);
    snap();
    tick();
    rd(5'h00, v); check("R7 snapshot frozen", v, 8'h10);
    snap();
    rd(5'h00, v); check("R7 snapshot refreshed", v, 8'h11);
    rd(5'h0D, v); check("R7 get bit reads 0", v, 8'h01);
    rd(5'h0E, v); check("R8 sec flag and run", v, 8'h06);
    wr(5'h0E, 8'hFF);
  endtask

  task automatic t_alarm();
    logic [7:0] v;
    wr(5'h07, 8'h31); wr(5'h08, 8'h20); wr(5'h09, 8'h10);
    wr(5'h0A, 8'h15); wr(5'h0B, 8'h06); wr(5'h0C, 8'h24);
    wr(5'h0F, 8'h08);
    load(8'h30, 8'h20, 8'h10, 8'h15, 8'h06, 8'h24);
    wr(5'h0E, 8'hFF);
    set_run(1'b1);
    tick();
    rd(5'h0E, v); check("R9 alarm flag", v & 8'h40, 8'h40);
    check("R11 alarm irq", {7'd0, irq}, 8'h01);
    wr(5'h0E, 8'h40);
    check("R11 irq drops on clear", {7'd0, irq}, 8'h00);
    wr(5'h0C, 8'h25);
    load(8'h30, 8'h20, 8'h10, 8'h15, 8'h06, 8'h24);
    set_run(1'b1);
    tick();
    rd(5'h0E, v); check("R9 year mismatch no flag", v & 8'h40, 8'h00);
    check("R11 no irq on mismatch", {7'd0, irq}, 8'h00);
    wr(5'h0E, 8'hFF);
  endtask

  task automatic t_periodic();
    load(8'h10, 8'h00, 8'h00, 8'h02, 8'h02, 8'h02);
    wr(5'h0F, 8'h05);
    wr(5'h0E, 8'hFF);
    set_run(1'b1);
    tick();
    check("R11 minute select masks second", {7'd0, irq}, 8'h00);
    load(8'h59, 8'h00, 8'h00, 8'h02, 8'h02, 8'h02);
    set_run(1'b1);
    tick();
    check("R11 minute event irq", {7'd0, irq}, 8'h01);
    repeat (3) @(negedge clk);
    check("R11 irq held", {7'd0, irq}, 8'h01);
    wr(5'h0E, 8'h08);
    check("R11 irq cleared", {7'd0, irq}, 8'h00);
    wr(5'h0F, 8'h04);
    check("R11 second select irq", {7'd0, irq}, 8'h01);
    wr(5'h0F, 8'h00);
    wr(5'h0E, 8'hFF);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    load(8'h45, 8'h00, 8'h00, 8'h03, 8'h03, 8'h03);
    set_run(1'b1);
    @(negedge clk); tick_1hz = 1'b1; addr = 5'h00; wr_data = 8'h30; wr_en = 1'b1;
    @(negedge clk); tick_1hz = 1'b0; wr_en = 1'b0;
    snap();
    rd(5'h00, v); check("R12 write wins over tick", v, 8'h30);
    wr(5'h0E, 8'hFF);
  endtask

  task automatic t_trim();
    logic [7:0] v;
    wr(5'h10, 8'hA5); wr(5'h11, 8'h3C);
    rd(5'h10, v); check("R13 trim low", v, 8'hA5);
    rd(5'h11, v); check("R13 trim high", v, 8'h3C);
    repeat (2) @(negedge clk);
    check("R13 rd_data held", rd_data, 8'h3C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_halt();
    t_century();
    t_month(8'h28, 8'h02, 8'h01, 8'h01, 8'h03, "feb common");
    t_month(8'h28, 8'h02, 8'h04, 8'h29, 8'h02, "feb leap");
    t_month(8'h29, 8'h02, 8'h04, 8'h01, 8'h03, "feb29 end");
    t_month(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, "feb year00");
    t_month(8'h30, 8'h04, 8'h10, 8'h01, 8'h05, "30-day");
    t_month(8'h30, 8'h01, 8'h10, 8'h31, 8'h01, "31-day mid");
    t_month(8'h31, 8'h01, 8'h10, 8'h01, 8'h02, "31-day end");
    t_weekday();
    t_snapshot();
    t_alarm();
    t_periodic();
    t_collide();
    t_trim();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule